// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block sequences the entry into and exit from a low-power state for a clock generator. An asynchronous active-low request pin is brought into the CPU-rate clock domain by a chain of flops. When the request is seen, every CPU-domain output gate is dropped on the next falling edge of that clock. The reference-domain gates are dropped on a falling edge of the reference clock. Only when both groups are confirmed low is the VCO enable removed, and the crystal enable is removed one cycle after that.

When the request is released, the crystal is restarted first and the VCO one cycle later. A counter then waits out a settling interval before the ready flag rises and the gates are reopened. Each gate enable comes from a flop clocked on the falling edge of its own domain's clock. The surrounding logic can AND it with that clock without producing runt pulses. The sequencing clock and the reference clock are assumed to be kept running by the surrounding logic throughout.

A stop sequence that has started always runs to the oscillator-off state, even if the request is withdrawn part way through. A request seen before the reference gates have confirmed they are running is held until they have.

Top module: `clk_pd_sequencer`

## Requirements
- R1: While reset is asserted, every gate enable (1 = output running, 0 = held low) and `ready` are 0, and `vco_en` and `xtal_en` are both 1.
- R2: After reset is released, `ready` rises on exactly the SETTLE_CYC-th rising edge of `cpu_clk`.
- R3: CPU gate enables rise on the first falling edge of `cpu_clk` after `ready` rises, and change only on falling edges of `cpu_clk`.
- R4: With the block running and the reference gates confirmed running, a fall of `pd_n` makes `ready` drop on the (SYNC_STAGES+1)-th rising edge of `cpu_clk`, and all CPU gate enables go to 0 on the falling edge that follows.
- R5: `vco_en` is 0 only while every CPU and reference gate enable is 0.
- R6: On entry, `vco_en` falls one `cpu_clk` cycle before `xtal_en` falls. On exit, `xtal_en` rises one cycle before `vco_en` rises.
- R7: A `pd_n` low pulse of one cycle still drives the full stop sequence, including `xtal_en` going low, and the block then restarts and raises `ready` again.
- R8: While `pd_n` stays low after the stop sequence, all gates, `ready`, `vco_en` and `xtal_en` stay 0.
- R9: After `pd_n` rises with the block fully stopped, `xtal_en` rises at rising edge SYNC_STAGES+1, `vco_en` at SYNC_STAGES+2, and `ready` at SYNC_STAGES+2+SETTLE_CYC. This total is checked at elaboration against MAX_RESTART_CYC.
- R10: Reference gate enables rise within 40 `cpu_clk` cycles of `ready` rising, and change only on falling edges of `ref_clk`.
- R11: A power-down request that arrives before the reference gates confirm they are running is not acted on until they do, so `ready` falls only while all reference gates are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-rate clock that runs the sequencer and the CPU gates |
| ref_clk | input | 1 | Free-running reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_gate_en | output | N_CPU | Per-output enables for the CPU-domain outputs, updated on falling edges of cpu_clk |
| ref_gate_en | output | N_REF | Per-output enables for the reference-domain outputs, updated on falling edges of ref_clk |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| ready | output | 1 | High while the block is running with oscillators settled |

## Verification
The assertions assume that both clocks keep toggling while the oscillator enables are low. They also assume that `pd_n` changes are seen by at least one rising edge of `cpu_clk`. The bench keeps both clocks free-running at unrelated periods, so clock-domain crossings happen at varied phases. It also drives `pd_n` only at falling edges of `cpu_clk`, which makes the synchronizer latency exact. Long power-down pulses are drawn at random so that the release always lands in the waiting state. The short-pulse and early-request cases are driven as directed tests.

// File: rtl/cpdseq_pkg.sv
package cpdseq_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_GATE_CPU = 3'd1,
      ST_GATE_REF = 3'd2,
      ST_OSC_OFF  = 3'd3,
      ST_WAIT_REL = 3'd4,
      ST_OSC_ON   = 3'd5,
      ST_SETTLE   = 3'd6
   } pd_state_e;

endpackage

// File: rtl/cpdseq_sync.sv
module cpdseq_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cpdseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= {STAGES{RST_VAL}};
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];

endmodule

// File: rtl/cpdseq_gate.sv
module cpdseq_gate #(
   parameter int N      = 1,
   parameter bit RESYNC = 1'b0,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   output logic [N-1:0] gate_en
);

   if (N < 1) begin : g_bad_n
      $error("cpdseq_gate: N must be at least 1");
   end

   logic req_loc;

   if (RESYNC) begin : g_resync
      cpdseq_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (req),
         .q     (req_loc)
      );
   end else begin : g_direct
      assign req_loc = req;
   end

   // Enables are updated only while the clock is low, so clk & gate_en has no runt pulse
   for (genvar i = 0; i < N; i++) begin : g_out
      logic en_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= req_loc;
      end
      assign gate_en[i] = en_q;
   end

endmodule

// File: rtl/cpdseq_fsm.sv
module cpdseq_fsm
   import cpdseq_pkg::*;
#(
   parameter int SETTLE_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_sync_n,
   input  logic cpu_all_low,
   input  logic ref_ack,
   output logic gate_req,
   output logic vco_en,
   output logic xtal_en,
   output logic ready
);

   localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
   localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("cpdseq_fsm: SETTLE_CYC must be at least 1");
   end

   pd_state_e      state;
   logic [CW-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_SETTLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_RUN:      if (!pd_sync_n && ref_ack) state <= ST_GATE_CPU;
            ST_GATE_CPU: if (cpu_all_low)           state <= ST_GATE_REF;
            ST_GATE_REF: if (!ref_ack)              state <= ST_OSC_OFF;
            ST_OSC_OFF:                             state <= ST_WAIT_REL;
            ST_WAIT_REL: if (pd_sync_n)             state <= ST_OSC_ON;
            ST_OSC_ON: begin
               state <= ST_SETTLE;
               cnt   <= '0;
            end
            ST_SETTLE: begin
               if (cnt == CNT_LAST) state <= ST_RUN;
               else                 cnt   <= cnt + 1'b1;
            end
            default:                                state <= ST_SETTLE;
         endcase
      end
   end

   assign gate_req = (state == ST_RUN);
   assign ready    = (state == ST_RUN);
   assign xtal_en  = (state != ST_WAIT_REL);
   assign vco_en   = !(state inside {ST_OSC_OFF, ST_WAIT_REL, ST_OSC_ON});

   AST_VCO_OFF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xtal_en) |-> !$past(vco_en)) else $error("AST_VCO_OFF_FIRST"); // R6
   AST_XTAL_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vco_en) |-> ($past(xtal_en) && xtal_en)) else $error("AST_XTAL_ON_FIRST"); // R6
   AST_HOLD_WHILE_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_REL && !pd_sync_n) |=> (state == ST_WAIT_REL)) else $error("AST_HOLD_WHILE_PD"); // R8
   AST_READY_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (vco_en && xtal_en)) else $error("AST_READY_OSC_ON"); // R9
   AST_EARLY_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !ref_ack) |=> (state == ST_RUN)) else $error("AST_EARLY_REQ_HELD"); // R11

endmodule

// File: rtl/clk_pd_sequencer.sv
module clk_pd_sequencer #(
   parameter int N_CPU           = 4,
   parameter int N_REF           = 2,
   parameter int SYNC_STAGES     = 2,
   parameter int SETTLE_CYC      = 64,
   parameter int MAX_RESTART_CYC = 100000
) (
   input  logic             cpu_clk,
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             pd_n,
   output logic [N_CPU-1:0] cpu_gate_en,
   output logic [N_REF-1:0] ref_gate_en,
   output logic             vco_en,
   output logic             xtal_en,
   output logic             ready
);

   localparam int RESTART_CYC = SYNC_STAGES + 2 + SETTLE_CYC;

   if (RESTART_CYC > MAX_RESTART_CYC) begin : g_bad_restart
      $error("clk_pd_sequencer: restart latency exceeds MAX_RESTART_CYC");
   end

   logic pd_sync_n;
   logic ref_ack;
   logic gate_req;

   cpdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
      .clk   (cpu_clk),
      .rst_n (rst_n),
      .d     (pd_n),
      .q     (pd_sync_n)
   );

   cpdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk   (cpu_clk),
      .rst_n (rst_n),
      .d     (|ref_gate_en),
      .q     (ref_ack)
   );

   cpdseq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
      .clk         (cpu_clk),
      .rst_n       (rst_n),
      .pd_sync_n   (pd_sync_n),
      .cpu_all_low (~|cpu_gate_en),
      .ref_ack     (ref_ack),
      .gate_req    (gate_req),
      .vco_en      (vco_en),
      .xtal_en     (xtal_en),
      .ready       (ready)
   );

   cpdseq_gate #(.N(N_CPU), .RESYNC(1'b0), .STAGES(SYNC_STAGES)) u_cpu_gate (
      .clk     (cpu_clk),
      .rst_n   (rst_n),
      .req     (gate_req),
      .gate_en (cpu_gate_en)
   );

   cpdseq_gate #(.N(N_REF), .RESYNC(1'b1), .STAGES(SYNC_STAGES)) u_ref_gate (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .req     (gate_req),
      .gate_en (ref_gate_en)
   );

   AST_OSC_OFF_GATES_LOW: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      !vco_en |-> (cpu_gate_en == '0 && ref_gate_en == '0)) else $error("AST_OSC_OFF_GATES_LOW"); // R5
   AST_CPU_RISE_IN_RUN: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      $rose(cpu_gate_en[0]) |-> ready) else $error("AST_CPU_RISE_IN_RUN"); // R3
   AST_CPU_GATES_AGREE: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (cpu_gate_en == '0) || (cpu_gate_en == '1)) else $error("AST_CPU_GATES_AGREE"); // R4

endmodule

// File: tb/clk_pd_sequencer_bench.sv
module clk_pd_sequencer_bench;

   localparam int CLK_PERIOD  = 10;
   localparam int REF_HALF    = 7;
   localparam int N_CPU       = 4;
   localparam int N_REF       = 2;
   localparam int SYNC_STAGES = 2;
   localparam int SETTLE_CYC  = 16;

   logic             cpu_clk = 1'b0;
   logic             ref_clk = 1'b0;
   logic             rst_n   = 1'b0;
   logic             pd_n    = 1'b1;
   logic [N_CPU-1:0] cpu_gate_en;
   logic [N_REF-1:0] ref_gate_en;
   logic             vco_en, xtal_en, ready;

   int checks = 0;
   int errors = 0;
   int cpu_mis = 0;
   int ref_mis = 0;
   bit mon_on = 1'b0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
   always #(REF_HALF)     ref_clk = ~ref_clk;

   clk_pd_sequencer #(
      .N_CPU(N_CPU), .N_REF(N_REF), .SYNC_STAGES(SYNC_STAGES),
      .SETTLE_CYC(SETTLE_CYC), .MAX_RESTART_CYC(1000)
   ) u_clk_pd_sequencer (
      .cpu_clk(cpu_clk), .ref_clk(ref_clk), .rst_n(rst_n), .pd_n(pd_n),
      .cpu_gate_en(cpu_gate_en), .ref_gate_en(ref_gate_en),
      .vco_en(vco_en), .xtal_en(xtal_en), .ready(ready)
   );

   function automatic int all_on_cpu(input logic [N_CPU-1:0] g);
      return (g == '1) ? 1 : 0;
   endfunction

   function automatic int all_on_ref(input logic [N_REF-1:0] g);
      return (g == '1) ? 1 : 0;
   endfunction

   function automatic int restart_latency();
      return SYNC_STAGES + 2 + SETTLE_CYC;
   endfunction

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge cpu_clk);
      #1;
   endtask

   // Gates may change only while their clock is low: compare just after the rising edge
   // with just before the falling edge (R3, R10)
   always @(posedge cpu_clk) begin
      logic [N_CPU-1:0] a;
      #1 a = cpu_gate_en;
      #(CLK_PERIOD/2 - 2);
      if (mon_on && cpu_gate_en != a) cpu_mis++;
   end

   always @(posedge ref_clk) begin
      logic [N_REF-1:0] a;
      #1 a = ref_gate_en;
      #(REF_HALF - 2);
      if (mon_on && ref_gate_en != a) ref_mis++;
   end

   task automatic wait_ref_up(input string req);
      int n = 0;
      while (!all_on_ref(ref_gate_en) && n < 40) begin
         tick(1);
         n++;
      end
      chk(all_on_ref(ref_gate_en), 1, req);
   endtask

   // Full power-down with a long low time, followed by the restart
   task automatic pd_cycle(input int width);
      int n;
      @(negedge cpu_clk);
      pd_n = 1'b0;
      n = 0;
      do begin tick(1); n++; end while (ready && n < 50);
      chk(n, SYNC_STAGES + 1, "R4 ready drop latency");
      chk(all_on_cpu(cpu_gate_en), 1, "R4 gates still on before falling edge");
      @(negedge cpu_clk); #1;
      chk(int'(cpu_gate_en), 0, "R4 gates low on falling edge");
      n = 0;
      while (vco_en && n < 200) begin tick(1); n++; end
      chk(int'(vco_en), 0, "R5 vco off reached");
      chk(int'(cpu_gate_en), 0, "R5 cpu gates low at vco off");
      chk(int'(ref_gate_en), 0, "R5 ref gates low at vco off");
      chk(int'(xtal_en), 1, "R6 xtal still on when vco drops");
      tick(1);
      chk(int'(xtal_en), 0, "R6 xtal off one cycle later");
      tick(width);
      chk(int'({cpu_gate_en, ref_gate_en, ready, vco_en, xtal_en}), 0, "R8 all held off");
      @(negedge cpu_clk);
      pd_n = 1'b1;
      tick(SYNC_STAGES + 1);
      chk(int'({xtal_en, vco_en}), 2, "R9 xtal on, vco off");
      tick(1);
      chk(int'(vco_en), 1, "R9 vco on");
      n = SYNC_STAGES + 2;
      while (!ready && n < 500) begin tick(1); n++; end
      chk(n, restart_latency(), "R9 restart latency");
      wait_ref_up("R10 ref gates up after restart");
      tick(2 * SYNC_STAGES + 4);
   endtask

   initial begin : main
      int n;
      bit saw_off;
      void'($urandom(32'd2718));
      tick(3);
      chk(int'({cpu_gate_en, ref_gate_en, ready}), 0, "R1 gates and ready low in reset");
      chk(int'({vco_en, xtal_en}), 3, "R1 oscillators on in reset");
      @(negedge cpu_clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      n = 0;
      do begin tick(1); n++; end while (!ready && n < 500);
      chk(n, SETTLE_CYC, "R2 first ready latency");
      chk(int'(cpu_gate_en), 0, "R3 gates low at ready rise");
      @(negedge cpu_clk); #1;
      chk(all_on_cpu(cpu_gate_en), 1, "R3 gates on at next falling edge");
      wait_ref_up("R10 ref gates up after reset");
      tick(2 * SYNC_STAGES + 4);

      pd_cycle(30);
      for (int i = 0; i < 6; i++) pd_cycle(5 + int'($urandom % 40));

      // R7: one-cycle request still completes the stop sequence
      @(negedge cpu_clk);
      pd_n = 1'b0;
      @(negedge cpu_clk);
      pd_n = 1'b1;
      saw_off = 1'b0;
      n = 0;
      do begin
         tick(1);
         n++;
         if (!xtal_en) saw_off = 1'b1;
      end while (!(saw_off && ready) && n < 300);
      chk(int'(saw_off), 1, "R7 short pulse reached oscillator off");
      chk(int'(ready), 1, "R7 ready back after short pulse");

      // R11: request right after ready, before the reference gates confirm
      @(negedge cpu_clk);
      pd_n = 1'b0;
      n = 0;
      while (ready && n < 100) begin tick(1); n++; end
      chk(all_on_ref(ref_gate_en), 1, "R11 ref gates running when ready falls");
      tick(40);
      @(negedge cpu_clk);
      pd_n = 1'b1;
      n = 0;
      while (!ready && n < 300) begin tick(1); n++; end
      chk(int'(ready), 1, "R11 restart after early request");
      wait_ref_up("R10 ref gates up after early request");
      tick(5);

      chk(cpu_mis, 0, "R3 cpu gates change only on falling edges");
      chk(ref_mis, 0, "R10 ref gates change only on falling edges");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule